// File: doc/BRIEF.md
# SPI Status and Event Flag Word

This block keeps the status and event flags of a serial peripheral interface controller in a single 32-bit word, read through a one-address register bus. It sits between the controller's transmit and receive datapaths and that bus. The datapath reports its events as one-cycle strobes: receive buffer loaded, receive data read, transmit data written, holding word moved to the shifter, slave character start and slave shift-clock demand. It also drives levels for the select lines, transmitter busy and stall. From these the block keeps the flags, and it presents the word, the four sticky event levels, an end-transfer request for the transmitter and a write enable for the receive buffer.

The word holds four kinds of bit. Some are live status taken straight from the datapath. Some are ready bits that hardware sets and clears. Some are sticky event bits that software clears by writing a 1. One is a control bit that software sets and hardware clears. In slave mode, a character that arrives while the receive buffer is still full is refused, so the data already buffered is kept.

Top module: `spi_flag_word`

## Requirements
- R1: When reset is released with transmitter busy and stall both low, the word reads 0x0000_0102: transmit-ready (bit 1) and master-idle (bit 8) are set and every other bit is clear.
- R2: Bit 0 (receive-ready) sets on an accepted receive-buffer load and clears on a receive-data read. When both happen in the same cycle, the load wins.
- R3: Bit 1 (transmit-ready) clears on a transmit-data write and sets on a move to the shifter. When both happen in the same cycle, the write wins and the bit ends up clear.
- R4: In slave mode, a character start while bit 0 is set sets bit 2 (receive overrun). While slave mode and bit 0 are both set, `rx_buf_load` stays low, so the buffered word is kept.
- R5: In slave mode, a shift-clock demand while the transmitter is not busy and bit 1 is set (holding register empty) sets bit 3 (transmit underrun). A demand while the holding register is full, or while the transmitter is busy, has no effect.
- R6: In master mode, character starts and shift-clock demands never set bit 2 or bit 3. A receive-buffer load in master mode is always accepted.
- R7: Bit 4 sets two clock edges after any select line changes from deasserted to asserted, even when other select lines are already asserted.
- R8: Bit 5 sets two clock edges after the select vector becomes all deasserted, having had at least one line asserted. A partial deassertion does not set it.
- R9: Bits 2 to 5 are sticky. A bus write with a 1 in a bit's position clears that bit, and a 0 leaves it unchanged. A hardware set and a software clear in the same cycle leave the bit set.
- R10: Writing 1 to bit 7 (end-transfer) sets it and raises `end_req`. The bit holds while the transmitter is not idle and clears at the first edge where master-idle is true. Writing 0 to it has no effect.
- R11: Bit 6 follows the stall input live. Bit 8 equals transmit-ready AND NOT transmitter-busy, live.
- R12: Bus writes to bits 0, 1, 6 and 8 are ignored, and bits 9 to 31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slave_mode | input | 1 | 1 = slave mode, 0 = master mode |
| bus_wr | input | 1 | Write strobe for the status word |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Status word |
| rx_load | input | 1 | Received character ready to load into the buffer |
| rx_read | input | 1 | Receive data register read |
| tx_write | input | 1 | Software wrote transmit data (with or without control) |
| tx_move | input | 1 | Holding word moved into the transmit shifter |
| slv_char_start | input | 1 | Start of a received character in slave mode |
| slv_clk_demand | input | 1 | Slave transmitter must send on the next shift clock |
| sel_asserted | input | NSEL | Select line levels, 1 = asserted |
| tx_busy | input | 1 | Transmitter is shifting |
| stall_live | input | 1 | Controller is stalled |
| rx_buf_load | output | 1 | Write enable to the receive buffer |
| event_flags | output | 4 | Sticky levels: overrun, underrun, select-assert, select-deassert |
| end_req | output | 1 | End-transfer request to the transmitter |

## Verification
The bench builds the block with four select lines and a 32-bit bus. With several lines it can raise one line while another stays asserted, which must still set bit 4. It can also drop one line while another stays asserted, which must not set bit 5. The full bus width lets writes put ones into the always-zero bits 9 to 31 and the read-only bits, and the bench checks that those bits do not change.

// File: rtl/spi_flag_word.sv
module spi_flag_word #(
  parameter int NSEL  = 4,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_mode,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             rx_load,
  input  logic             rx_read,
  input  logic             tx_write,
  input  logic             tx_move,
  input  logic             slv_char_start,
  input  logic             slv_clk_demand,
  input  logic [NSEL-1:0]  sel_asserted,
  input  logic             tx_busy,
  input  logic             stall_live,
  output logic             rx_buf_load,
  output logic [3:0]       event_flags,
  output logic             end_req
);

  localparam int NSTICKY = 4;
  localparam int STICKY_LO = 2;
  localparam int END_BIT = 7;
  localparam int USED_W = 9;

  logic rx_ready, tx_ready, mst_idle;
  logic [NSEL-1:0] sel_q, sel_qq;
  logic [NSTICKY-1:0] sticky, sticky_set, sticky_clr;
  logic sel_rise, sel_fall;

  assign rx_buf_load = rx_load & ~(slave_mode & rx_ready);
  assign mst_idle    = tx_ready & ~tx_busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_ready <= 1'b0;
    else if (rx_buf_load) rx_ready <= 1'b1;
    else if (rx_read) rx_ready <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_ready <= 1'b1;
    else if (tx_write) tx_ready <= 1'b0;
    else if (tx_move) tx_ready <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q  <= '0;
      sel_qq <= '0;
    end else begin
      sel_q  <= sel_asserted;
      sel_qq <= sel_q;
    end

  assign sel_rise = |(sel_q & ~sel_qq);
  assign sel_fall = (|sel_qq) & ~(|sel_q);

  assign sticky_set[0] = slave_mode & slv_char_start & rx_ready;
  assign sticky_set[1] = slave_mode & slv_clk_demand & ~tx_busy & tx_ready;
  assign sticky_set[2] = sel_rise;
  assign sticky_set[3] = sel_fall;
  assign sticky_clr    = bus_wr ? bus_wdata[STICKY_LO +: NSTICKY] : '0;

  for (genvar g = 0; g < NSTICKY; g++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sticky[g] <= 1'b0;
      else sticky[g] <= sticky_set[g] | (sticky[g] & ~sticky_clr[g]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) end_req <= 1'b0;
    else if (bus_wr && bus_wdata[END_BIT]) end_req <= 1'b1;
    else if (mst_idle) end_req <= 1'b0;

  assign event_flags = sticky;
  assign bus_rdata = {{(BUS_W-USED_W){1'b0}}, mst_idle, end_req, stall_live,
                      sticky, tx_ready, rx_ready};

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[BUS_W-1:END_BIT+1], bus_wdata[STICKY_LO+NSTICKY],
                          bus_wdata[STICKY_LO-1:0]};

  a_r2_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load && !(slave_mode && rx_ready) |=> rx_ready);
  a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_write |=> !tx_ready && !bus_rdata[8]);
  a_r4_keep_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode && rx_ready |-> !rx_buf_load);
  a_r6_master_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_mode && !event_flags[1] |=> !event_flags[1]);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode && slv_char_start && rx_ready |=> event_flags[0]);
  a_r10_end_hold: assert property (@(posedge clk) disable iff (!rst_n)
    end_req && !mst_idle |=> end_req);
  a_r10_end_clear: assert property (@(posedge clk) disable iff (!rst_n)
    end_req && mst_idle && !(bus_wr && bus_wdata[END_BIT]) |=> !end_req);
  a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[BUS_W-1:USED_W] == '0);

endmodule

// File: tb/spi_flag_word_tb_top.sv
module spi_flag_word_tb_top;
  localparam int NSEL = 4;
  localparam int BUS_W = 32;

  logic clk = 0, rst_n = 0;
  logic slave_mode = 0, bus_wr = 0;
  logic [BUS_W-1:0] bus_wdata = '0, bus_rdata;
  logic rx_load = 0, rx_read = 0, tx_write = 0, tx_move = 0;
  logic slv_char_start = 0, slv_clk_demand = 0;
  logic [NSEL-1:0] sel_asserted = '0;
  logic tx_busy = 0, stall_live = 0;
  logic rx_buf_load, end_req;
  logic [3:0] event_flags;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  spi_flag_word #(.NSEL(NSEL), .BUS_W(BUS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_load(rx_load),
    .rx_read(rx_read), .tx_write(tx_write), .tx_move(tx_move),
    .slv_char_start(slv_char_start), .slv_clk_demand(slv_clk_demand),
    .sel_asserted(sel_asserted), .tx_busy(tx_busy), .stall_live(stall_live),
    .rx_buf_load(rx_buf_load), .event_flags(event_flags), .end_req(end_req));

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e || event_flags !== e[5:2] || end_req !== e[7]) begin
        n_fail++;
        $display("FAIL %s: got word %h flags %b end %b, expected word %h", t,
                 bus_rdata, event_flags, end_req, e);
      end
    end
  end

  task automatic step(input bit chk, input logic [31:0] e, input string t);
    if (chk) begin
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0; rx_load = 0; rx_read = 0; tx_write = 0;
    tx_move = 0; slv_char_start = 0; slv_clk_demand = 0;
  endtask

  task automatic wr(input logic [31:0] d, input logic [31:0] e, input string t);
    bus_wr = 1; bus_wdata = d;
    step(1, e, t);
  endtask

  task automatic chk_now(input logic got, input logic e, input string t);
    n_chk++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", t, got, e);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(1, 32'h102, "R1 reset word");

    rx_load = 1; step(1, 32'h103, "R2 load sets");
    rx_read = 1; step(1, 32'h102, "R2 read clears");
    rx_load = 1; rx_read = 1; step(1, 32'h103, "R2 load beats read");
    rx_read = 1; step(1, 32'h102, "R2 read clears again");

    tx_write = 1; step(1, 32'h000, "R3 write clears");
    tx_busy = 1; tx_move = 1; step(1, 32'h002, "R3 move sets, R11 busy blocks idle");
    tx_write = 1; tx_move = 1; step(1, 32'h000, "R3 write beats move");
    tx_move = 1; step(1, 32'h002, "R3 move sets");
    tx_busy = 0; step(1, 32'h102, "R11 idle returns");
    stall_live = 1; step(1, 32'h142, "R11 stall live");
    stall_live = 0; step(1, 32'h102, "R11 stall drop");

    wr(32'hFFFF_FF43, 32'h102, "R12 read-only and upper bits");
    rx_load = 1; step(1, 32'h103, "R12 prep");
    wr(32'h0000_0000, 32'h103, "R12 zero write");
    wr(32'h0000_0001, 32'h103, "R12 bit0 write ignored");
    rx_read = 1; step(1, 32'h102, "R12 cleanup");

    slave_mode = 1;
    rx_load = 1; #1; chk_now(rx_buf_load, 1'b1, "R4 load accepted when empty");
    step(1, 32'h103, "R4 first char");
    rx_load = 1; slv_char_start = 1; #1;
    chk_now(rx_buf_load, 1'b0, "R4 buffer kept");
    step(1, 32'h107, "R4 overrun set");
    rx_read = 1; step(1, 32'h106, "R4 read keeps sticky");

    wr(32'h0, 32'h106, "R9 zero write no clear");
    wr(32'h4, 32'h102, "R9 w1c overrun");
    rx_load = 1; step(1, 32'h103, "R9 prep");
    slv_char_start = 1; bus_wr = 1; bus_wdata = 32'h4;
    step(1, 32'h107, "R9 set beats clear");
    wr(32'h4, 32'h103, "R9 clear after");
    rx_read = 1; step(1, 32'h102, "R9 cleanup");

    slv_clk_demand = 1; step(1, 32'h10A, "R5 underrun set");
    wr(32'h8, 32'h102, "R5 w1c underrun");
    tx_write = 1; step(1, 32'h000, "R5 fill holding");
    slv_clk_demand = 1; step(1, 32'h000, "R5 no underrun when full");
    tx_move = 1; step(1, 32'h102, "R5 moved");
    tx_busy = 1; step(1, 32'h002, "R5 busy");
    slv_clk_demand = 1; step(1, 32'h002, "R5 no underrun when busy");
    tx_busy = 0; step(1, 32'h102, "R5 idle");

    slave_mode = 0;
    rx_load = 1; step(1, 32'h103, "R6 prep");
    rx_load = 1; slv_char_start = 1; #1;
    chk_now(rx_buf_load, 1'b1, "R6 master load accepted");
    step(1, 32'h103, "R6 no overrun in master");
    slv_clk_demand = 1; step(1, 32'h103, "R6 no underrun in master");
    rx_read = 1; step(1, 32'h102, "R6 cleanup");

    sel_asserted = 4'b0010; step(1, 32'h102, "R7 one edge later still clear");
    step(1, 32'h112, "R7 assert flag");
    wr(32'h10, 32'h102, "R9 w1c assert flag");
    sel_asserted = 4'b0110; step(1, 32'h102, "R7 second line pending");
    step(1, 32'h112, "R7 second line sets");
    wr(32'h10, 32'h102, "R7 clear");
    sel_asserted = 4'b0100; step(1, 32'h102, "R8 partial");
    step(1, 32'h102, "R8 partial no flag");
    sel_asserted = 4'b0000; step(1, 32'h102, "R8 pending");
    step(1, 32'h122, "R8 deassert flag");
    wr(32'h20, 32'h102, "R8 clear");

    tx_write = 1; step(1, 32'h000, "R10 prep");
    tx_busy = 1; wr(32'h80, 32'h080, "R10 set end");
    tx_move = 1; step(1, 32'h082, "R10 hold while busy");
    step(1, 32'h082, "R10 hold");
    wr(32'h0, 32'h082, "R10 zero write no effect");
    tx_busy = 0; step(1, 32'h102, "R10 cleared at idle");
    step(1, 32'h102, "R10 stays clear");

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule